// File: doc/BRIEF.md
# Dual-Mode Gated Frequency Counter

This block measures the frequency of one of several digital input signals with a single shared accumulator. In direct mode it counts rising edges of the chosen input over a gate window. The gate window is a decade multiple of a slow reference tick. In reciprocal mode it counts pulses of a decade-divided copy of its own clock over exactly one period of the input. The caller then turns the count into a frequency by division.

A measurement begins with a start pulse. The mode, source, range and auto-range choice are held until the measurement ends. With auto-range on, the counter begins at the finest resolution, range code 0. It moves one code coarser each time the accumulator would wrap, and retries until a result fits. The result is held in a register with its mode and range code. A valid flag marks a new result and is cleared by a read strobe.

Top module: `freq_counter`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `res_valid`, `res_overflow`, `res_timeout`, `res_recip` and `res_count` are all zero.
- R2: A `start` pulse while idle begins a measurement and raises `busy`. At that moment the block captures `mode_recip`, `auto_range` and `range_sel`. A `start` pulse while `busy` is high has no effect on the running measurement or its result.
- R3: Direct mode (`mode_recip`=0) opens the gate on the first `gate_tick` after start. It then counts the synchronized rising edges of the selected input until 10^(GATE_DECADES-1-code) further ticks have passed. The gate includes the edge seen on the closing tick.
- R4: Reciprocal mode (`mode_recip`=1) waits for a rising edge of the selected input. It then counts clock-enable pulses at the clock rate divided by 10^code until the next rising edge. At code 0 the result equals the input period in clock cycles, and at code c it is floor(period / 10^c).
- R5: `src_sel` = i picks `sig_in[i]` for i < N_SRC. Any larger value selects a constant low input.
- R6: If the accumulator would pass 2^ACC_W-1 and no coarser range is allowed, the result shows `res_overflow`=1, `res_count` all ones and the range code that was in use.
- R7: With `auto_range`=1, the measurement starts at code 0. Each would-be wrap raises the code by one and restarts the measurement. The code used is reported in `res_range`.
- R8: In reciprocal mode, if the accumulator wraps while waiting for the first edge at the last allowed code, the result shows `res_timeout`=1, `res_count` all ones and `res_recip`=1. The flags `res_overflow` and `res_timeout` are never both set.
- R9: `res_valid` rises in the cycle where `busy` falls and stays set until a `res_read` strobe. It is set if a result completes in the same cycle as the strobe. The result fields change only at completion.
- R10: A fixed `range_sel` above the top code for the mode is clamped to that top code. The top code is GATE_DECADES-1 in direct mode and CLK_DECADES-1 in reciprocal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the fastest reciprocal count rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | N_SRC | Asynchronous signals to be measured |
| src_sel | input | SEL_W | Index of the measured signal |
| gate_tick | input | 1 | One-cycle reference tick that times gate windows |
| start | input | 1 | Pulse to begin a measurement |
| mode_recip | input | 1 | 0 = direct count, 1 = reciprocal count |
| auto_range | input | 1 | 1 = choose the range code automatically |
| range_sel | input | RANGE_W | Fixed range code when auto-range is off |
| res_read | input | 1 | Read strobe; clears the valid flag |
| busy | output | 1 | Measurement in progress |
| res_valid | output | 1 | Unread result available |
| res_count | output | ACC_W | Measured count |
| res_recip | output | 1 | Mode of the held result |
| res_range | output | RANGE_W | Range code of the held result |
| res_overflow | output | 1 | Result overflowed at the coarsest range allowed |
| res_timeout | output | 1 | No input edge arrived in reciprocal mode |

## Verification
The bench uses a narrow accumulator, so auto-range must step past code 0 in both modes. A design that kept the first range, or did not restart its gate and prescaler on a retry, would report code 0 or a count that is off by the stale prescaler phase. A source index beyond the last input must give a timeout. Wrong index decoding would instead return a period from some real source. Start pulses during a measurement and read strobes are placed so that a design that re-latched mode or range mid-run, or dropped a result completing beside a read, would show the wrong tag or a missing valid flag. Gate boundaries are set so the exact edge count is known: a window one cycle short or long, or a lost edge on the closing tick, changes the count.

// File: rtl/fc_pkg.sv
// Shared types and constant helpers for the frequency counter.
// Assumes: nothing beyond IEEE 1800-2017.
package fc_pkg;

    // Controller phases: idle, waiting for the gate/first edge, counting.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_MEAS = 2'd2
    } fc_state_e;

    // Integer power used only for elaboration-time sizes.
    function automatic int dec_pow(input int base, input int exp_n);
        int v;
        v = 1;
        for (int i = 0; i < exp_n; i++) begin
            v = v * base;
        end
        return v;
    endfunction

endpackage

// File: rtl/fc_input_sync.sv
// Picks one of the asynchronous inputs, brings it into the clock domain
// through two flops and flags its rising edges (one cycle per edge).
// Assumes: out-of-range selections read as a constant low input.
module fc_input_sync #(
    parameter int N_SRC = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] sig_in,
    input  logic [SEL_W-1:0] src_sel,
    output logic             rise
);

    logic picked;
    logic meta_q, sync_q, prev_q;

    // Source multiplexer; unmatched codes leave the output low.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (src_sel == SEL_W'(i)) begin
                picked = sig_in[i];
            end
        end
    end

    // Two-flop synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= picked;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

endmodule

// File: rtl/fc_prescaler.sv
// Decade divider chain on the reference clock. Stage k fires once every
// DEC_RATIO^k cycles; the range code picks the stage driving the output.
// Assumes: clr restarts all stages so the first pulse lands 10^code cycles
// after it.
module fc_prescaler #(
    parameter int CLK_DECADES = 3,
    parameter int DEC_RATIO   = 10,
    parameter int RANGE_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [RANGE_W-1:0] code,
    output logic               cnt_en
);

    localparam int DIV_W = $clog2(DEC_RATIO);

    logic [CLK_DECADES-1:0] stage_en;

    assign stage_en[0] = 1'b1;

    for (genvar k = 1; k < CLK_DECADES; k++) begin : g_stage
        logic [DIV_W-1:0] div_q;

        // Divide the previous stage's pulses by DEC_RATIO.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                div_q <= '0;
            end else if (stage_en[k-1]) begin
                div_q <= (div_q == DIV_W'(DEC_RATIO - 1)) ? '0 : div_q + 1'b1;
            end
        end

        assign stage_en[k] = stage_en[k-1] && (div_q == DIV_W'(DEC_RATIO - 1));
    end

    // Route the stage chosen by the range code; unknown codes stay quiet.
    always_comb begin
        cnt_en = 1'b0;
        for (int i = 0; i < CLK_DECADES; i++) begin
            if (code == RANGE_W'(i)) begin
                cnt_en = stage_en[i];
            end
        end
    end

endmodule

// File: rtl/fc_accum.sv
// The single shared counter. Clear beats increment; wrap marks an
// increment that would roll the all-ones value over to zero.
// Assumes: the controller never lets a wrapped value reach the result.
module fc_accum #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [ACC_W-1:0] val,
    output logic             wrap
);

    // Count register with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            val <= '0;
        end else if (inc) begin
            val <= val + 1'b1;
        end
    end

    assign wrap = inc && (val == '1);

endmodule

// File: rtl/fc_ctrl.sv
// Measurement sequencer, auto-range stepping and result register.
// Assumes: gate_tick is a single-cycle pulse synchronous to clk and that
// rise/cnt_en come from the sync and prescaler blocks in this cycle.
module fc_ctrl
    import fc_pkg::*;
#(
    parameter int ACC_W        = 16,
    parameter int GATE_DECADES = 5,
    parameter int CLK_DECADES  = 3,
    parameter int DEC_RATIO    = 10,
    parameter int RANGE_W      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode_recip,
    input  logic               auto_range,
    input  logic [RANGE_W-1:0] range_sel,
    input  logic               res_read,
    input  logic               gate_tick,
    input  logic               rise,
    input  logic               cnt_en,
    input  logic [ACC_W-1:0]   acc_val,
    input  logic               acc_wrap,
    output logic               acc_clr,
    output logic               acc_inc,
    output logic               presc_clr,
    output logic [RANGE_W-1:0] code,
    output logic               busy,
    output logic               res_valid,
    output logic [ACC_W-1:0]   res_count,
    output logic               res_recip,
    output logic [RANGE_W-1:0] res_range,
    output logic               res_overflow,
    output logic               res_timeout
);

    localparam int               MAX_TICKS = dec_pow(DEC_RATIO, GATE_DECADES - 1);
    localparam int               TK_W      = $clog2(MAX_TICKS + 1);
    localparam logic [RANGE_W-1:0] GMAX    = RANGE_W'(GATE_DECADES - 1);
    localparam logic [RANGE_W-1:0] CMAX    = RANGE_W'(CLK_DECADES - 1);

    fc_state_e        state;
    logic             md_q;
    logic             auto_q;
    logic [TK_W-1:0]  tk_q;
    logic [TK_W-1:0]  gate_last;
    logic [RANGE_W-1:0] run_max;
    logic [RANGE_W-1:0] new_max;
    logic [RANGE_W-1:0] first_code;
    logic             retry;
    logic             gate_done;
    logic             fin_ok, fin_ovf, fin_to;
    int               glen;

    // Number of ticks in the gate for the current code, minus one.
    always_comb begin
        glen = 1;
        for (int i = 0; i < GATE_DECADES - 1; i++) begin
            if (i < (GATE_DECADES - 1 - int'(code))) begin
                glen = glen * DEC_RATIO;
            end
        end
        gate_last = TK_W'(glen - 1);
    end

    // Range limits and the starting code of a new measurement.
    always_comb begin
        run_max    = md_q ? CMAX : GMAX;
        new_max    = mode_recip ? CMAX : GMAX;
        first_code = auto_range ? '0 : ((range_sel > new_max) ? new_max : range_sel);
        retry      = auto_q && (code < run_max);
    end

    // Counter steering and the three ways a measurement can end.
    always_comb begin
        acc_inc   = ((state == ST_ARM) && md_q && cnt_en) ||
                    ((state == ST_MEAS) && (md_q ? cnt_en : rise));
        gate_done = !md_q && gate_tick && (tk_q == gate_last);
        fin_ok    = (state == ST_MEAS) && !acc_wrap && (md_q ? rise : gate_done);
        fin_ovf   = (state == ST_MEAS) && acc_wrap && !retry;
        fin_to    = (state == ST_ARM) && md_q && !rise && acc_wrap && !retry;
        acc_clr   = ((state == ST_IDLE) && start) ||
                    ((state == ST_ARM) && !md_q && gate_tick) ||
                    ((state == ST_ARM) && md_q && rise) ||
                    ((state == ST_ARM) && md_q && acc_wrap && retry) ||
                    ((state == ST_MEAS) && acc_wrap && retry);
        presc_clr = ((state == ST_IDLE) && start) ||
                    ((state == ST_ARM) && md_q && rise) ||
                    ((state == ST_ARM) && md_q && acc_wrap && retry) ||
                    ((state == ST_MEAS) && acc_wrap && retry);
    end

    // Sequencer: capture settings, wait for the gate or first edge, count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            md_q   <= 1'b0;
            auto_q <= 1'b0;
            code   <= '0;
            tk_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_ARM;
                        md_q   <= mode_recip;
                        auto_q <= auto_range;
                        code   <= first_code;
                    end
                end
                ST_ARM: begin
                    if (!md_q && gate_tick) begin
                        state <= ST_MEAS;
                        tk_q  <= '0;
                    end else if (md_q && rise) begin
                        state <= ST_MEAS;
                    end else if (md_q && acc_wrap) begin
                        if (retry) begin
                            code <= code + 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_MEAS: begin
                    if (acc_wrap) begin
                        if (retry) begin
                            code  <= code + 1'b1;
                            state <= ST_ARM;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (fin_ok) begin
                        state <= ST_IDLE;
                    end else if (!md_q && gate_tick) begin
                        tk_q <= tk_q + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result register: completion wins over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_count    <= '0;
            res_recip    <= 1'b0;
            res_range    <= '0;
            res_overflow <= 1'b0;
            res_timeout  <= 1'b0;
        end else if (fin_ok || fin_ovf || fin_to) begin
            res_valid    <= 1'b1;
            res_count    <= fin_ok ? ACC_W'(acc_val + ACC_W'(acc_inc)) : '1;
            res_recip    <= md_q;
            res_range    <= code;
            res_overflow <= fin_ovf;
            res_timeout  <= fin_to;
        end else if (res_read) begin
            res_valid <= 1'b0;
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/freq_counter.sv
// Top of the dual-mode frequency counter: input selection and edge
// detection, decade prescaler, shared accumulator and sequencer.
// Assumes: clk is the reference clock; gate_tick is a synchronous
// one-cycle pulse at the gate reference rate.
module freq_counter #(
    parameter int N_SRC        = 3,
    parameter int SEL_W        = 2,
    parameter int ACC_W        = 16,
    parameter int GATE_DECADES = 5,
    parameter int CLK_DECADES  = 3,
    parameter int DEC_RATIO    = 10,
    parameter int RANGE_W      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   sig_in,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               gate_tick,
    input  logic               start,
    input  logic               mode_recip,
    input  logic               auto_range,
    input  logic [RANGE_W-1:0] range_sel,
    input  logic               res_read,
    output logic               busy,
    output logic               res_valid,
    output logic [ACC_W-1:0]   res_count,
    output logic               res_recip,
    output logic [RANGE_W-1:0] res_range,
    output logic               res_overflow,
    output logic               res_timeout
);

    logic               rise;
    logic               cnt_en;
    logic               presc_clr;
    logic               acc_clr;
    logic               acc_inc;
    logic               acc_wrap;
    logic [ACC_W-1:0]   acc_val;
    logic [RANGE_W-1:0] code;

    fc_input_sync #(
        .N_SRC (N_SRC),
        .SEL_W (SEL_W)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (sig_in),
        .src_sel (src_sel),
        .rise    (rise)
    );

    fc_prescaler #(
        .CLK_DECADES (CLK_DECADES),
        .DEC_RATIO   (DEC_RATIO),
        .RANGE_W     (RANGE_W)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (presc_clr),
        .code   (code),
        .cnt_en (cnt_en)
    );

    fc_accum #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .inc   (acc_inc),
        .val   (acc_val),
        .wrap  (acc_wrap)
    );

    fc_ctrl #(
        .ACC_W        (ACC_W),
        .GATE_DECADES (GATE_DECADES),
        .CLK_DECADES  (CLK_DECADES),
        .DEC_RATIO    (DEC_RATIO),
        .RANGE_W      (RANGE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mode_recip   (mode_recip),
        .auto_range   (auto_range),
        .range_sel    (range_sel),
        .res_read     (res_read),
        .gate_tick    (gate_tick),
        .rise         (rise),
        .cnt_en       (cnt_en),
        .acc_val      (acc_val),
        .acc_wrap     (acc_wrap),
        .acc_clr      (acc_clr),
        .acc_inc      (acc_inc),
        .presc_clr    (presc_clr),
        .code         (code),
        .busy         (busy),
        .res_valid    (res_valid),
        .res_count    (res_count),
        .res_recip    (res_recip),
        .res_range    (res_range),
        .res_overflow (res_overflow),
        .res_timeout  (res_timeout)
    );

endmodule

// File: rtl/freq_counter_chk.sv
// Protocol checks on the counter's ports, bound into every instance.
// Assumes: reset is held for at least one clock before release.
module freq_counter_chk #(
    parameter int ACC_W        = 16,
    parameter int GATE_DECADES = 5,
    parameter int CLK_DECADES  = 3,
    parameter int RANGE_W      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               res_read,
    input logic               busy,
    input logic               res_valid,
    input logic [ACC_W-1:0]   res_count,
    input logic               res_recip,
    input logic [RANGE_W-1:0] res_range,
    input logic               res_overflow,
    input logic               res_timeout
);

    localparam logic [RANGE_W-1:0] GMAX = RANGE_W'(GATE_DECADES - 1);
    localparam logic [RANGE_W-1:0] CMAX = RANGE_W'(CLK_DECADES - 1);

    assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_valid_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $fell(busy));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_read && !busy) |=> !res_valid);

    assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(res_count));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_overflow |-> (res_count == '1));

    assert_flags_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_overflow && res_timeout));

    assert_timeout_recip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_timeout |-> res_recip);

    assert_range_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_recip ? (res_range <= CMAX) : (res_range <= GMAX)));

endmodule

bind freq_counter freq_counter_chk #(
    .ACC_W        (ACC_W),
    .GATE_DECADES (GATE_DECADES),
    .CLK_DECADES  (CLK_DECADES),
    .RANGE_W      (RANGE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .res_read     (res_read),
    .busy         (busy),
    .res_valid    (res_valid),
    .res_count    (res_count),
    .res_recip    (res_recip),
    .res_range    (res_range),
    .res_overflow (res_overflow),
    .res_timeout  (res_timeout)
);

// File: tb/freq_counter_test.sv
// Bench: a behavioural reference model runs beside the design and is
// compared every clock; directed runs add closed-form count checks.
module freq_counter_test;

    localparam int CLK_T  = 10;
    localparam int ACC_W  = 8;
    localparam int GDEC   = 4;
    localparam int CDEC   = 3;
    localparam int TICK_T = 8;
    localparam int FULL   = (1 << ACC_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sig_in = '0;
    logic [1:0] src_sel = '0;
    logic       gate_tick = 1'b0;
    logic       start = 1'b0;
    logic       mode_recip = 1'b0;
    logic       auto_range = 1'b0;
    logic [2:0] range_sel = '0;
    logic       res_read = 1'b0;
    logic       busy, res_valid, res_recip, res_overflow, res_timeout;
    logic [ACC_W-1:0] res_count;
    logic [2:0] res_range;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit done = 0;

    freq_counter #(
        .ACC_W (ACC_W), .GATE_DECADES (GDEC), .CLK_DECADES (CDEC)
    ) uut (
        .clk (clk), .rst_n (rst_n), .sig_in (sig_in), .src_sel (src_sel),
        .gate_tick (gate_tick), .start (start), .mode_recip (mode_recip),
        .auto_range (auto_range), .range_sel (range_sel), .res_read (res_read),
        .busy (busy), .res_valid (res_valid), .res_count (res_count),
        .res_recip (res_recip), .res_range (res_range),
        .res_overflow (res_overflow), .res_timeout (res_timeout)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic chk(input string tag, input int got, input int expv);
        n_chk++;
        if (got !== expv) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, got, expv);
        end
    endtask

    // Stimulus sources: periods 4, 50 and 300 cycles; tick every TICK_T.
    always @(negedge clk) begin
        cyc++;
        sig_in[0] <= (cyc % 4) < 2;
        sig_in[1] <= (cyc % 50) < 25;
        sig_in[2] <= (cyc % 300) < 150;
        gate_tick <= (cyc % TICK_T) == 0;
    end

    // Reference model state.
    int m_state, m_mode, m_auto, m_code, m_acc, m_tk, m_pre;
    int m_valid, m_cnt, m_recip, m_range, m_ovf, m_to;
    int h0, h1, h2;

    always @(posedge clk) begin
        int edge_now, j, en, clr, mx, inc, fin, glen;
        if (!rst_n) begin
            m_state = 0; m_mode = 0; m_auto = 0; m_code = 0; m_acc = 0;
            m_tk = 0; m_pre = 0; m_valid = 0; m_cnt = 0; m_recip = 0;
            m_range = 0; m_ovf = 0; m_to = 0; h0 = 0; h1 = 0; h2 = 0;
        end else begin
            edge_now = h1 & ~h2;
            h2 = h1; h1 = h0;
            h0 = (src_sel < 3) ? int'(sig_in[src_sel]) : 0;
            j = m_pre + 1;
            en = ((j % (10 ** m_code)) == 0);
            clr = 0; fin = 0;
            mx = m_mode ? CDEC - 1 : GDEC - 1;
            glen = 10 ** (GDEC - 1 - m_code);
            if (res_read) m_valid = 0;
            case (m_state)
                0: if (start) begin
                    m_mode = mode_recip; m_auto = auto_range;
                    mx = m_mode ? CDEC - 1 : GDEC - 1;
                    m_code = m_auto ? 0 : ((int'(range_sel) > mx) ? mx : int'(range_sel));
                    m_state = 1; clr = 1; m_acc = 0;
                end
                1: if (!m_mode) begin
                    if (gate_tick) begin m_state = 2; m_acc = 0; m_tk = 0; end
                end else if (edge_now) begin
                    m_state = 2; m_acc = 0; clr = 1;
                end else if (en) begin
                    if (m_acc == FULL) begin
                        if (m_auto && m_code < mx) begin m_code++; m_acc = 0; clr = 1; end
                        else begin fin = 3; end
                    end else m_acc++;
                end
                2: begin
                    inc = m_mode ? en : edge_now;
                    if (inc && m_acc == FULL) begin
                        if (m_auto && m_code < mx) begin
                            m_code++; m_acc = 0; clr = 1; m_state = 1;
                        end else fin = 2;
                    end else if (m_mode ? edge_now : (gate_tick && m_tk == glen - 1)) begin
                        fin = 1; m_cnt = m_acc + inc;
                    end else begin
                        m_acc += inc;
                        if (!m_mode && gate_tick) m_tk++;
                    end
                end
                default: m_state = 0;
            endcase
            m_pre = clr ? 0 : j;
            if (fin != 0) begin
                m_valid = 1; m_state = 0;
                if (fin != 1) m_cnt = FULL;
                m_ovf = (fin == 2); m_to = (fin == 3);
                m_recip = m_mode; m_range = m_code;
            end
        end
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 busy vs model", int'(busy), int'(m_state != 0));
            chk("R9 valid vs model", int'(res_valid), m_valid);
            if (m_valid != 0) begin
                chk("R3 count vs model", int'(res_count), m_cnt);
                chk("R6 overflow vs model", int'(res_overflow), m_ovf);
                chk("R8 timeout vs model", int'(res_timeout), m_to);
                chk("R4 mode vs model", int'(res_recip), m_recip);
                chk("R7 range vs model", int'(res_range), m_range);
            end
        end
    end

    int g_cnt, g_rng, g_md, g_ovf, g_to;

    task automatic measure(input int rc, input int ar, input int rng, input int sel);
        @(negedge clk);
        src_sel = 2'(sel); mode_recip = rc[0]; auto_range = ar[0]; range_sel = 3'(rng);
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(res_valid && !busy)) @(negedge clk);
        g_cnt = int'(res_count); g_rng = int'(res_range); g_md = int'(res_recip);
        g_ovf = int'(res_overflow); g_to = int'(res_timeout);
        res_read = 1'b1;
        @(negedge clk);
        res_read = 1'b0;
    endtask

    initial begin
        #(CLK_T * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 valid", int'(res_valid), 0);
        chk("R1 count", int'(res_count), 0);
        chk("R1 flags", int'(res_overflow) + int'(res_timeout) + int'(res_recip), 0);
        rst_n = 1'b1;
        cmp_on = 1;

        // R3: direct gate 10 ticks of 8 cycles on a period-4 input
        measure(0, 0, 2, 0);
        chk("R3 direct code2", g_cnt, 20);
        chk("R3 direct range", g_rng, 2);
        measure(0, 0, 3, 0);
        chk("R3 direct code3", g_cnt, 2);

        // R5: second source, gate 100 ticks, period 50
        measure(0, 0, 1, 1);
        chk("R5 direct src1", g_cnt, 16);

        // R4: reciprocal periods
        measure(1, 0, 0, 0);
        chk("R4 recip period4", g_cnt, 4);
        measure(1, 0, 0, 1);
        chk("R4 recip period50", g_cnt, 50);
        measure(1, 0, 1, 1);
        chk("R4 recip period50 code1", g_cnt, 5);
        chk("R4 recip tag", g_md, 1);

        // R6: fixed longest gate overflows
        measure(0, 0, 0, 0);
        chk("R6 overflow flag", g_ovf, 1);
        chk("R6 saturated count", g_cnt, FULL);
        chk("R6 range kept", g_rng, 0);

        // R7: auto-range steps to the first fitting code
        measure(0, 1, 3, 0);
        chk("R7 auto direct count", g_cnt, 200);
        chk("R7 auto direct range", g_rng, 1);
        chk("R7 auto direct no ovf", g_ovf, 0);
        measure(1, 1, 0, 2);
        chk("R7 auto recip count", g_cnt, 30);
        chk("R7 auto recip range", g_rng, 1);

        // R8 and R5: out-of-range select reads constant low -> timeout
        measure(1, 0, 0, 3);
        chk("R8 timeout flag", g_to, 1);
        chk("R8 timeout count", g_cnt, FULL);
        chk("R5 unused select", g_ovf, 0);

        // R10: clamping of fixed range codes
        measure(0, 0, 7, 0);
        chk("R10 direct clamp range", g_rng, 3);
        chk("R10 direct clamp count", g_cnt, 2);
        measure(1, 0, 6, 2);
        chk("R10 recip clamp range", g_rng, 2);
        chk("R10 recip clamp count", g_cnt, 3);

        // R2: start while busy is ignored
        @(negedge clk);
        src_sel = 2'd0; mode_recip = 1'b0; auto_range = 1'b0; range_sel = 3'd2;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        repeat (3) @(negedge clk);
        mode_recip = 1'b1; range_sel = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(res_valid && !busy)) @(negedge clk);
        chk("R2 mode unchanged", int'(res_recip), 0);
        chk("R2 count unchanged", int'(res_count), 20);

        // R9: valid holds until read, then clears
        repeat (3) @(negedge clk);
        chk("R9 valid held", int'(res_valid), 1);
        res_read = 1'b1;
        @(negedge clk);
        res_read = 1'b0;
        chk("R9 valid cleared", int'(res_valid), 0);
        chk("R9 count kept", int'(res_count), 20);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule